// File: doc/BRIEF.md
# APB Four-Window Read-Return Hub

This block sits between one APB requester and four APB completers. It turns the requester's select and address into one select line per completer, and it builds the single response the requester sees. Each completer owns one 4 KB window. Address bits 13:12 pick the window, and address bits 15:14 must be zero for the address to be mapped. Bits above 15 play no part in the decode.

Read data comes back over a shared bitwise-OR return. This only works if every completer that is not selected drives all zeros. The ready and error responses do not use the OR: they are taken from the selected completer alone.

An address that lands outside the four windows is never passed to a completer. The hub answers it itself, in the first ACCESS cycle, with an error and a fixed marker word. A sticky flag records any read ACCESS cycle in which a completer that does not own the transfer presents nonzero data. This exposes a completer that breaks the zero-when-unselected rule, which would otherwise corrupt the addressed completer's data without any visible sign.

Top module: `apb_rdret_hub`

## Requirements
- R1: While `req_psel` is high and `req_paddr[15:14]` is 2'b00, exactly one bit of `cmp_psel` is high: bit number `req_paddr[13:12]`. Address bits above 15 are ignored. In every other case `cmp_psel` is all zeros.
- R2: `cmp_psel` holds the same value through the SETUP cycle and every ACCESS cycle of a transfer whose address is held steady.
- R3: For a mapped transfer, `req_prdata` is the bitwise OR of all four completer data words. With well-behaved completers, this is the selected completer's data.
- R4: For a mapped transfer, `req_pready` and `req_pslverr` equal the selected completer's ready and error bits. The ready and error bits of the other completers have no effect.
- R5: For an unmapped transfer (`req_paddr[15:14]` not 2'b00), no completer is selected. The hub drives `req_pready` high in the first ACCESS cycle, with `req_pslverr` high and `req_prdata` = 32'hDEADDEAD.
- R6: `own_violation` goes high on the clock edge that ends a read ACCESS cycle (psel, penable, write low) in which any non-selected completer presents nonzero data. During an unmapped read, every completer counts as non-selected.
- R7: `own_violation` is low after the synchronous active-high reset. Once set, it stays high until the next reset.
- R8: Nonzero data from a non-selected completer during a write ACCESS cycle, or while `req_psel` is low, leaves `own_violation` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_psel | input | 1 | Requester select |
| req_penable | input | 1 | Requester enable (ACCESS phase) |
| req_pwrite | input | 1 | Requester direction, 1 = write |
| req_paddr | input | 32 | Requester address |
| req_prdata | output | 32 | Combined read data to requester |
| req_pready | output | 1 | Ready to requester |
| req_pslverr | output | 1 | Error to requester |
| cmp_psel | output | 4 | One select line per completer |
| cmp_prdata | input | 128 | Completer read data, completer k in bits 32k+31:32k |
| cmp_pready | input | 4 | Completer ready bits |
| cmp_pslverr | input | 4 | Completer error bits |
| own_violation | output | 1 | Sticky flag: a non-owner drove nonzero read data |

## Verification
The selects, read data, ready and error outputs are combinational functions of the current inputs. They are due in the same cycle as the stimulus, so the bench drives one time unit after the rising edge and compares at the falling edge of that same cycle. The select vector is checked in the SETUP cycle and again in each ACCESS cycle. Data and error are compared by the scoreboard monitor only at the falling edge of the cycle in which ready is high, which is the cycle the requester would sample. The ownership flag passes through one register, so the bench reads it just after the rising edge that closes the transfer, and for idle or write stimulus it reads it after the cycles in which the stray data was present.

// File: rtl/apb_rr_pkg.sv
`timescale 1ns/1ps
package apb_rr_pkg;

  // How the current requester access is being served.
  typedef enum logic [1:0] {
    RT_IDLE = 2'd0,  // no select from requester
    RT_SLOT = 2'd1,  // routed to one completer window
    RT_HOLE = 2'd2   // outside every window, answered locally
  } route_e;

endpackage

// File: rtl/apb_rr_decode.sv
`timescale 1ns/1ps
module apb_rr_decode
  import apb_rr_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int N_SLOTS  = 4,
  parameter int SLOT_LSB = 12,
  parameter int MAP_MSB  = 15,
  localparam int IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic              psel,
  input  logic [ADDR_W-1:0] paddr,
  output logic [N_SLOTS-1:0] slot_sel,
  output logic [IDX_W-1:0]  slot_idx,
  output route_e            route
);

  localparam int GUARD_LSB = SLOT_LSB + IDX_W;

  logic guard_set;

  // Bits between the window index and the top of the map must be zero.
  generate
    if (MAP_MSB >= GUARD_LSB) begin : g_guard
      assign guard_set = |paddr[MAP_MSB:GUARD_LSB];
    end else begin : g_noguard
      assign guard_set = 1'b0;
    end
  endgenerate

  assign slot_idx = paddr[SLOT_LSB +: IDX_W];

  always_comb begin
    slot_sel = '0;
    route    = RT_IDLE;
    if (psel) begin
      if (guard_set) begin
        route = RT_HOLE;
      end else begin
        route              = RT_SLOT;
        slot_sel[slot_idx] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/apb_rr_or_fold.sv
`timescale 1ns/1ps
module apb_rr_or_fold #(
  parameter int N_SLOTS = 4,
  parameter int DATA_W  = 32
) (
  input  logic [N_SLOTS*DATA_W-1:0] lanes,
  output logic [DATA_W-1:0]         folded,
  output logic [N_SLOTS-1:0]        nonzero
);

  // Per-slot activity: does this completer present any set bit.
  generate
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_nz
      assign nonzero[g] = |lanes[g*DATA_W +: DATA_W];
    end
  endgenerate

  always_comb begin
    folded = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      folded = folded | lanes[i*DATA_W +: DATA_W];
    end
  end

endmodule

// File: rtl/apb_rr_resp.sv
`timescale 1ns/1ps
module apb_rr_resp
  import apb_rr_pkg::*;
#(
  parameter int              N_SLOTS   = 4,
  parameter int              DATA_W    = 32,
  parameter logic [DATA_W-1:0] HOLE_WORD = 32'hDEAD_DEAD,
  localparam int             IDX_W     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  route_e             route,
  input  logic               penable,
  input  logic [IDX_W-1:0]   slot_idx,
  input  logic [DATA_W-1:0]  or_data,
  input  logic [N_SLOTS-1:0] slot_ready,
  input  logic [N_SLOTS-1:0] slot_err,
  output logic [DATA_W-1:0]  rdata,
  output logic               ready,
  output logic               err
);

  always_comb begin
    rdata = or_data;
    ready = 1'b0;
    err   = 1'b0;
    unique case (route)
      RT_SLOT: begin
        // Only the owner's handshake bits reach the requester.
        ready = slot_ready[slot_idx];
        err   = slot_err[slot_idx];
      end
      RT_HOLE: begin
        // Answer locally, no wait states, flagged as an error.
        rdata = HOLE_WORD;
        ready = penable;
        err   = penable;
      end
      default: begin
        ready = 1'b0;
        err   = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/apb_rr_owner_watch.sv
`timescale 1ns/1ps
module apb_rr_owner_watch #(
  parameter int N_SLOTS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_access,
  input  logic [N_SLOTS-1:0] slot_sel,
  input  logic [N_SLOTS-1:0] slot_nonzero,
  output logic               flag
);

  logic [N_SLOTS-1:0] stray;

  generate
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_stray
      assign stray[g] = slot_nonzero[g] & ~slot_sel[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (rd_access && (|stray)) begin
      flag <= 1'b1;
    end
  end

endmodule

// File: rtl/apb_rdret_hub.sv
`timescale 1ns/1ps
module apb_rdret_hub
  import apb_rr_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 32,
  parameter int              N_SLOTS   = 4,
  parameter int              SLOT_LSB  = 12,
  parameter int              MAP_MSB   = 15,
  parameter logic [DATA_W-1:0] HOLE_WORD = 32'hDEAD_DEAD
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_psel,
  input  logic                      req_penable,
  input  logic                      req_pwrite,
  input  logic [ADDR_W-1:0]         req_paddr,
  output logic [DATA_W-1:0]         req_prdata,
  output logic                      req_pready,
  output logic                      req_pslverr,
  output logic [N_SLOTS-1:0]        cmp_psel,
  input  logic [N_SLOTS*DATA_W-1:0] cmp_prdata,
  input  logic [N_SLOTS-1:0]        cmp_pready,
  input  logic [N_SLOTS-1:0]        cmp_pslverr,
  output logic                      own_violation
);

  localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

  route_e             route;
  logic [IDX_W-1:0]   slot_idx;
  logic [DATA_W-1:0]  or_data;
  logic [N_SLOTS-1:0] slot_nz;
  logic               rd_access;

  assign rd_access = req_psel & req_penable & ~req_pwrite;

  apb_rr_decode #(
    .ADDR_W  (ADDR_W),
    .N_SLOTS (N_SLOTS),
    .SLOT_LSB(SLOT_LSB),
    .MAP_MSB (MAP_MSB)
  ) u_decode (
    .psel    (req_psel),
    .paddr   (req_paddr),
    .slot_sel(cmp_psel),
    .slot_idx(slot_idx),
    .route   (route)
  );

  apb_rr_or_fold #(
    .N_SLOTS(N_SLOTS),
    .DATA_W (DATA_W)
  ) u_fold (
    .lanes  (cmp_prdata),
    .folded (or_data),
    .nonzero(slot_nz)
  );

  apb_rr_resp #(
    .N_SLOTS  (N_SLOTS),
    .DATA_W   (DATA_W),
    .HOLE_WORD(HOLE_WORD)
  ) u_resp (
    .route     (route),
    .penable   (req_penable),
    .slot_idx  (slot_idx),
    .or_data   (or_data),
    .slot_ready(cmp_pready),
    .slot_err  (cmp_pslverr),
    .rdata     (req_prdata),
    .ready     (req_pready),
    .err       (req_pslverr)
  );

  apb_rr_owner_watch #(
    .N_SLOTS(N_SLOTS)
  ) u_watch (
    .clk         (clk),
    .rst         (rst),
    .rd_access   (rd_access),
    .slot_sel    (cmp_psel),
    .slot_nonzero(slot_nz),
    .flag        (own_violation)
  );

endmodule

// File: rtl/apb_rr_checker.sv
`timescale 1ns/1ps
module apb_rr_checker #(
  parameter int              ADDR_W    = 32,
  parameter int              DATA_W    = 32,
  parameter int              N_SLOTS   = 4,
  parameter int              SLOT_LSB  = 12,
  parameter int              MAP_MSB   = 15,
  parameter logic [DATA_W-1:0] HOLE_WORD = 32'hDEAD_DEAD
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_psel,
  input logic                      req_penable,
  input logic                      req_pwrite,
  input logic [ADDR_W-1:0]         req_paddr,
  input logic [DATA_W-1:0]         req_prdata,
  input logic                      req_pready,
  input logic                      req_pslverr,
  input logic [N_SLOTS-1:0]        cmp_psel,
  input logic [N_SLOTS*DATA_W-1:0] cmp_prdata,
  input logic [N_SLOTS-1:0]        cmp_pready,
  input logic [N_SLOTS-1:0]        cmp_pslverr,
  input logic                      own_violation
);

  localparam int IDX_W     = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam int GUARD_LSB = SLOT_LSB + IDX_W;

  logic [IDX_W-1:0]   win;
  logic               unmapped;
  logic [N_SLOTS-1:0] busy;
  logic [DATA_W-1:0]  merged;
  logic               foreign;

  assign win = req_paddr[SLOT_LSB +: IDX_W];

  always_comb begin
    unmapped = 1'b0;
    for (int b = GUARD_LSB; b <= MAP_MSB; b++) begin
      unmapped = unmapped | req_paddr[b];
    end
    merged = '0;
    for (int s = 0; s < N_SLOTS; s++) begin
      busy[s] = (cmp_prdata[s*DATA_W +: DATA_W] != '0);
      merged  = merged | cmp_prdata[s*DATA_W +: DATA_W];
    end
    foreign = |(busy & ~cmp_psel);
  end

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmp_psel));

  assert_sel_target_R1: assert property (@(posedge clk) disable iff (rst)
    (req_psel && !unmapped) |-> (cmp_psel[win] && $countones(cmp_psel) == 1));

  assert_sel_idle_R1: assert property (@(posedge clk) disable iff (rst)
    (!req_psel || unmapped) |-> (cmp_psel == '0));

  assert_sel_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(req_psel && !req_penable) && req_psel && req_penable &&
     $stable(req_paddr)) |-> $stable(cmp_psel));

  assert_rdata_or_R3: assert property (@(posedge clk) disable iff (rst)
    (req_psel && !unmapped) |-> (req_prdata == merged));

  assert_resp_owner_R4: assert property (@(posedge clk) disable iff (rst)
    (req_psel && !unmapped) |->
      (req_pready == cmp_pready[win] && req_pslverr == cmp_pslverr[win]));

  assert_hole_answer_R5: assert property (@(posedge clk) disable iff (rst)
    (req_psel && req_penable && unmapped) |->
      (req_pready && req_pslverr && req_prdata == HOLE_WORD));

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
    (req_psel && req_penable && !req_pwrite && foreign) |=> own_violation);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    own_violation |=> own_violation);

  assert_flag_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!own_violation && !(req_psel && req_penable && !req_pwrite)) |=> !own_violation);

endmodule

bind apb_rdret_hub apb_rr_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .N_SLOTS  (N_SLOTS),
  .SLOT_LSB (SLOT_LSB),
  .MAP_MSB  (MAP_MSB),
  .HOLE_WORD(HOLE_WORD)
) u_rr_checker (.*);

// File: tb/apb_rdret_hub_bench.sv
`timescale 1ns/1ps
module apb_rdret_hub_bench;

  localparam int N  = 4;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam logic [DW-1:0] MARK = 32'hDEADDEAD;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_psel, req_penable, req_pwrite;
  logic [AW-1:0] req_paddr;
  logic [DW-1:0] req_prdata;
  logic          req_pready, req_pslverr;
  logic [N-1:0]  cmp_psel;
  logic [N*DW-1:0] cmp_prdata;
  logic [N-1:0]  cmp_pready, cmp_pslverr;
  logic          own_violation;

  always #2.5 clk = ~clk;

  apb_rdret_hub u_apb_rdret_hub (
    .clk(clk), .rst(rst),
    .req_psel(req_psel), .req_penable(req_penable), .req_pwrite(req_pwrite),
    .req_paddr(req_paddr), .req_prdata(req_prdata), .req_pready(req_pready),
    .req_pslverr(req_pslverr), .cmp_psel(cmp_psel), .cmp_prdata(cmp_prdata),
    .cmp_pready(cmp_pready), .cmp_pslverr(cmp_pslverr),
    .own_violation(own_violation)
  );

  typedef struct {
    logic [DW-1:0] data;
    logic          err;
    logic [N-1:0]  sel;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   fails  = 0;
  logic flag_exp = 1'b0;
  bit   done = 1'b0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: pops one expected completion whenever the requester would sample.
  always @(negedge clk) begin
    exp_t e;
    if (!rst && req_psel && req_penable && req_pready) begin
      if (sb_q.size() == 0) begin
        chk("R4/R5 completion with nothing pending", 1, 0);
      end else begin
        e = sb_q.pop_front();
        chk("R3/R5 read data", req_prdata, e.data);
        chk("R4/R5 error bit", {31'd0, req_pslverr}, {31'd0, e.err});
        chk("R1 select at completion", {28'd0, cmp_psel}, {28'd0, e.sel});
      end
    end
  end

  task automatic do_reset();
    @(posedge clk) #1;
    rst = 1'b1;
    req_psel = 0; req_penable = 0; req_pwrite = 0; req_paddr = '0;
    cmp_prdata = '0; cmp_pready = '0; cmp_pslverr = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    flag_exp = 1'b0;
    @(negedge clk);
    chk("R7 flag after reset", {31'd0, own_violation}, 0);
    chk("R1 no select after reset", {28'd0, cmp_psel}, 0);
    chk("R5 no ready while idle", {31'd0, req_pready}, 0);
  endtask

  // One requester transfer. rogue < 0 means no stray driver.
  task automatic xfer(input logic [AW-1:0] addr, input bit wr, input int waits,
                      input logic [DW-1:0] rdval, input bit serr,
                      input int rogue, input logic [DW-1:0] rogue_val);
    exp_t e;
    bit   hole = |addr[15:14];
    int   idx  = int'(addr[13:12]);
    int   nacc = hole ? 1 : waits + 1;
    logic [N-1:0] esel = hole ? '0 : (N'(1) << idx);
    e.sel  = esel;
    e.err  = hole ? 1'b1 : serr;
    e.data = hole ? MARK : ((wr ? '0 : rdval) | ((rogue >= 0) ? rogue_val : '0));
    if (!wr && rogue >= 0 && rogue_val != '0 && (hole || rogue != idx)) flag_exp = 1'b1;
    sb_q.push_back(e);

    @(posedge clk) #1;
    req_psel = 1; req_penable = 0; req_pwrite = wr; req_paddr = addr;
    cmp_pready = '1; cmp_pslverr = '1; cmp_prdata = '0;
    @(negedge clk);
    chk("R1/R2 select in SETUP", {28'd0, cmp_psel}, {28'd0, esel});
    for (int k = 0; k < nacc; k++) begin
      @(posedge clk) #1;
      req_penable = 1;
      cmp_prdata  = '0;
      if (!hole) begin
        cmp_pready[idx]  = (k == waits);
        cmp_pslverr[idx] = serr;
        if (!wr) cmp_prdata[idx*DW +: DW] = rdval;
      end
      if (rogue >= 0) cmp_prdata[rogue*DW +: DW] = cmp_prdata[rogue*DW +: DW] | rogue_val;
      @(negedge clk);
      chk("R2 select held in ACCESS", {28'd0, cmp_psel}, {28'd0, esel});
      if (k < nacc - 1) chk("R4 ready low while owner waits", {31'd0, req_pready}, 0);
    end
    @(posedge clk) #1;
    req_psel = 0; req_penable = 0; cmp_prdata = '0;
    chk("R4/R5 transfer completed exactly once", sb_q.size(), 0);
    sb_q.delete();
    chk("R6/R7/R8 ownership flag", {31'd0, own_violation}, {31'd0, flag_exp});
  endtask

  task automatic idle_stray(input int slot, input logic [DW-1:0] val);
    @(posedge clk) #1;
    req_psel = 0; req_penable = 0;
    cmp_prdata = '0;
    cmp_prdata[slot*DW +: DW] = val;
    repeat (3) @(posedge clk);
    #1 cmp_prdata = '0;
    chk("R8 stray data while idle leaves flag", {31'd0, own_violation}, {31'd0, flag_exp});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    rst = 1'b1;
    do_reset();
    // R1 R3 R4: each window, varied wait states, other completers' handshake high
    xfer(32'h0000_0010, 0, 0, 32'h1111_0001, 0, -1, '0);
    xfer(32'h0000_1004, 0, 2, 32'h2222_0002, 0, -1, '0);
    xfer(32'h0000_2008, 0, 1, 32'h3333_0003, 0, -1, '0);
    xfer(32'h0000_3FFC, 0, 3, 32'h4444_0004, 0, -1, '0);
    // R4: owner error propagates
    xfer(32'h0000_1000, 0, 1, 32'h0BAD_0001, 1, -1, '0);
    // R1: bits above 15 ignored
    xfer(32'hABCD_2000, 0, 0, 32'h5555_AAAA, 0, -1, '0);
    // R4: write transfer completes on owner ready
    xfer(32'h0000_3000, 1, 2, '0, 0, -1, '0);
    // R5: holes with each guard pattern
    xfer(32'h0000_4000, 0, 0, '0, 0, -1, '0);
    xfer(32'h0000_8123, 0, 0, '0, 0, -1, '0);
    xfer(32'h0000_C000, 1, 0, '0, 0, -1, '0);
    // R8: stray during write, stray while idle
    xfer(32'h0000_0000, 1, 1, '0, 0, 2, 32'h0000_00F0);
    idle_stray(1, 32'hFFFF_FFFF);
    // R6: stray during a read, data shows the OR (R3)
    xfer(32'h0000_1000, 0, 1, 32'h0000_1200, 0, 3, 32'h8000_0000);
    // R7: clean reads afterwards keep the flag high
    xfer(32'h0000_0000, 0, 0, 32'h7777_7777, 0, -1, '0);
    do_reset();
    // R6: stray during an unmapped read also sets the flag
    xfer(32'h0000_4000, 0, 0, '0, 0, 0, 32'h0000_0001);
    do_reset();
    done = 1'b1;
    summary();
  end

endmodule